// File: doc/BRIEF.md
# Flash Toggle-Bit Status Generator

This block produces the busy-status word that a flash device places on its data bus while an internal program or erase runs. A small controller outside the block tells it the current operation mode and sends a single pulse on the final write of each command sequence. The block also receives the erase-selection and protection masks. On every read strobe the block decides whether to return array data or a status word. The status word has two toggling flags. Bit 6 changes on every status read while a program or erase is actually running. Bit 2 changes only on reads aimed at a sector that is selected for erase.

A command that hits only protected sectors performs no work. The block still reports it as busy for a fixed time: about 1 µs for a program and about 100 µs for an erase. The counts come from a clock-frequency parameter. After that window, reads return array data until the next command. The bit-5 time-exceeded flag and every bit other than 6, 5 and 2 come in on inputs.

Top module: `flash_toggle_status`

## Requirements
- R1: After reset, `rdValid` and `rdData` are 0, and both toggle flags hold 0. With no command yet issued, the first status read in a busy mode returns bit 6 = 1.
- R2: The mode codes are idle 0, program 1, erase 2, erase-suspended 3 and suspend-program 4. In codes 1, 2 and 4, when no protected-command state is in effect, every read at any sector returns the status word. Its bit 6 is the inverse of the bit 6 returned by the previous status read.
- R3: Bit 2 inverts on a read whose sector has its bit set in `eraseMask` in modes 2, 3 and 4. It keeps its value on reads of sectors that are not selected.
- R4: In mode 3, a read of a selected sector returns the status word with bit 6 unchanged. A read of any other sector returns `arrayData`.
- R5: In mode 0 (and codes 5 to 7), reads return `arrayData` and leave both toggle flags unchanged.
- R6: A `cmdDone` pulse clears both toggle flags to 0. A read in the same cycle as `cmdDone` is served with the state from before the pulse.
- R7: When `cmdDone` arrives in mode 1 or 4 and the `protMask` bit for `cmdSector` is set, reads in the next CLK_MHZ×SHORT_US cycles return the status word with bit 6 toggling. Later reads return `arrayData` until the next `cmdDone`.
- R8: When `cmdDone` arrives in mode 2 and no sector is both selected and unprotected, reads in the next CLK_MHZ×LONG_US cycles return the status word with bit 6 toggling and bit 2 held. Later reads return `arrayData` until the next `cmdDone`.
- R9: A cycle with `rdStrobe` low drives `rdValid` to 0, keeps `rdData`, and leaves both toggle flags unchanged.
- R10: In the status word, bit 5 equals `exceedFlag`, and every bit other than 6, 5 and 2 equals the same bit of `statusFill`.
- R11: `rdValid` and `rdData` appear on the clock edge after the edge that samples `rdStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | One read cycle per high cycle |
| rdSector | input | SEC_W | Sector addressed by the read |
| opMode | input | 3 | Operation mode code |
| cmdDone | input | 1 | Final write pulse of a command sequence |
| cmdSector | input | SEC_W | Target sector of a program command |
| eraseMask | input | SECTORS | Sectors selected for erase |
| protMask | input | SECTORS | Protected sectors |
| arrayData | input | DATA_W | Array contents for the addressed location |
| statusFill | input | DATA_W | Fixed bits of the status word |
| exceedFlag | input | 1 | Time-exceeded flag driven onto bit 5 |
| rdValid | output | 1 | Read result valid |
| rdData | output | DATA_W | Read result |

## Verification
Two functions can land in the same cycle: a read and a `cmdDone` pulse. The bench raises `rdStrobe` together with a new command in suspend-program mode. The reference model then expects that read to return the flags from before the pulse, and the following read to start again from cleared flags. A second clash is a read in the last cycle of a protected-command window. The bench reads on every cycle across both window lengths, so the exact cycle where status gives way to array data is compared against the model.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE     = 3'd0,
    MODE_PROG     = 3'd1,
    MODE_ERASE    = 3'd2,
    MODE_ESUSP    = 3'd3,
    MODE_SUSPPROG = 3'd4
  } opMode_e;

  localparam int TGL_I_POS  = 6;
  localparam int EXCEED_POS = 5;
  localparam int TGL_II_POS = 2;

  typedef struct packed {
    logic rdFire;
    logic useStatus;
    logic flip6;
    logic flip2;
    logic clearTgl;
  } tglStrobe_t;

endpackage

// File: rtl/fts_ctrl.sv
`timescale 1ns/1ps
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int SECTORS   = 16,
  parameter int SEC_W     = 4,
  parameter int SHORT_CYC = 250,
  parameter int LONG_CYC  = 25000,
  parameter int CNT_W     = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdStrobe,
  input  logic [SEC_W-1:0]   rdSector,
  input  logic [2:0]         opMode,
  input  logic               cmdDone,
  input  logic [SEC_W-1:0]   cmdSector,
  input  logic [SECTORS-1:0] eraseMask,
  input  logic [SECTORS-1:0] protMask,
  output tglStrobe_t         strb
);

  logic [SECTORS-1:0] rdHit;
  logic [SECTORS-1:0] cmdHit;

  generate
    for (genvar s = 0; s < SECTORS; s++) begin : g_sec
      assign rdHit[s]  = (rdSector == SEC_W'(s));
      assign cmdHit[s] = (cmdSector == SEC_W'(s));
    end
  endgenerate

  logic selHit, progProt, eraseLive;
  assign selHit    = |(rdHit & eraseMask);
  assign progProt  = |(cmdHit & protMask);
  assign eraseLive = |(eraseMask & ~protMask);

  logic isProg, isErase, isSusp, isActive, isEraseCtx;
  always_comb begin
    isProg  = 1'b0;
    isErase = 1'b0;
    isSusp  = 1'b0;
    case (opMode)
      MODE_PROG:     isProg  = 1'b1;
      MODE_SUSPPROG: isProg  = 1'b1;
      MODE_ERASE:    isErase = 1'b1;
      MODE_ESUSP:    isSusp  = 1'b1;
      default: ;
    endcase
    isActive   = isProg | isErase;
    isEraseCtx = isErase | isSusp | (opMode == MODE_SUSPPROG);
  end

  logic             blocked;
  logic [CNT_W-1:0] winCnt;
  logic             falseBusy;
  logic             cmdBlocks;
  logic [CNT_W-1:0] winLoad;

  assign falseBusy = (winCnt != '0);
  assign cmdBlocks = (isProg & progProt) | (isErase & ~eraseLive);
  assign winLoad   = isProg ? CNT_W'(SHORT_CYC) : CNT_W'(LONG_CYC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blocked <= 1'b0;
      winCnt  <= '0;
    end else if (cmdDone) begin
      blocked <= cmdBlocks;
      winCnt  <= cmdBlocks ? winLoad : '0;
    end else if (falseBusy) begin
      winCnt  <= winCnt - CNT_W'(1);
    end
  end

  always_comb begin
    strb.rdFire    = rdStrobe;
    strb.clearTgl  = cmdDone;
    strb.flip6     = rdStrobe & (falseBusy | (~blocked & isActive));
    strb.flip2     = rdStrobe & ~blocked & isEraseCtx & selHit;
    strb.useStatus = falseBusy | (~blocked & (isActive | (isSusp & selHit)));
  end

  assert_window_steps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (falseBusy && !cmdDone) |=> (winCnt == $past(winCnt) - CNT_W'(1)));

  assert_window_toggles_R7: assert property (@(posedge clk) disable iff (!rstN)
    (falseBusy && rdStrobe) |-> (strb.useStatus && strb.flip6));

  assert_blocked_bit2_R8: assert property (@(posedge clk) disable iff (!rstN)
    blocked |-> !strb.flip2);

  assert_suspend_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_ESUSP && !falseBusy) |-> !strb.flip6);

  assert_idle_array_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_IDLE && !falseBusy) |-> (!strb.useStatus && !strb.flip6 && !strb.flip2));

endmodule

// File: rtl/fts_datapath.sv
`timescale 1ns/1ps
module fts_datapath
  import fts_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tglStrobe_t        strb,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] statusFill,
  input  logic              exceedFlag,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  logic tog6, tog2;
  logic next6, next2;
  logic [DATA_W-1:0] statusWord;

  assign next6 = strb.flip6 ? ~tog6 : tog6;
  assign next2 = strb.flip2 ? ~tog2 : tog2;

  always_comb begin
    statusWord             = statusFill;
    statusWord[TGL_I_POS]  = next6;
    statusWord[EXCEED_POS] = exceedFlag;
    statusWord[TGL_II_POS] = next2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (strb.clearTgl) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else begin
      tog6 <= next6;
      tog2 <= next2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdFire;
      if (strb.rdFire) rdData <= strb.useStatus ? statusWord : arrayData;
    end
  end

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdFire |=> rdValid);

  assert_no_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdFire |=> (!rdValid && $stable(rdData)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rdFire && !strb.clearTgl) |=> ($stable(tog6) && $stable(tog2)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearTgl |=> (!tog6 && !tog2));

  assert_flip_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flip6 && !strb.clearTgl) |=> (tog6 != $past(tog6)));

endmodule

// File: rtl/flash_toggle_status.sv
`timescale 1ns/1ps
module flash_toggle_status
  import fts_pkg::*;
#(
  parameter int SECTORS  = 16,
  parameter int DATA_W   = 16,
  parameter int CLK_MHZ  = 250,
  parameter int SHORT_US = 1,
  parameter int LONG_US  = 100,
  parameter int SEC_W    = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdStrobe,
  input  logic [SEC_W-1:0]   rdSector,
  input  logic [2:0]         opMode,
  input  logic               cmdDone,
  input  logic [SEC_W-1:0]   cmdSector,
  input  logic [SECTORS-1:0] eraseMask,
  input  logic [SECTORS-1:0] protMask,
  input  logic [DATA_W-1:0]  arrayData,
  input  logic [DATA_W-1:0]  statusFill,
  input  logic               exceedFlag,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData
);

  localparam int SHORT_CYC = CLK_MHZ * SHORT_US;
  localparam int LONG_CYC  = CLK_MHZ * LONG_US;
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  tglStrobe_t strb;

  fts_ctrl #(
    .SECTORS(SECTORS), .SEC_W(SEC_W), .SHORT_CYC(SHORT_CYC),
    .LONG_CYC(LONG_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdSector(rdSector),
    .opMode(opMode), .cmdDone(cmdDone), .cmdSector(cmdSector),
    .eraseMask(eraseMask), .protMask(protMask), .strb(strb)
  );

  fts_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .arrayData(arrayData),
    .statusFill(statusFill), .exceedFlag(exceedFlag),
    .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/flash_toggle_status_test.sv
`timescale 1ns/1ps
module flash_toggle_status_test;

  localparam int SECTORS   = 16;
  localparam int SEC_W     = 4;
  localparam int DATA_W    = 16;
  localparam int SHORT_CYC = 250;
  localparam int LONG_CYC  = 25000;

  logic               clk = 1'b0;
  logic               rstN;
  logic               rdStrobe;
  logic [SEC_W-1:0]   rdSector;
  logic [2:0]         opMode;
  logic               cmdDone;
  logic [SEC_W-1:0]   cmdSector;
  logic [SECTORS-1:0] eraseMask;
  logic [SECTORS-1:0] protMask;
  logic [DATA_W-1:0]  arrayData;
  logic [DATA_W-1:0]  statusFill;
  logic               exceedFlag;
  logic               rdValid;
  logic [DATA_W-1:0]  rdData;

  flash_toggle_status #(.SECTORS(SECTORS), .DATA_W(DATA_W), .CLK_MHZ(250)) uut (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdSector(rdSector),
    .opMode(opMode), .cmdDone(cmdDone), .cmdSector(cmdSector),
    .eraseMask(eraseMask), .protMask(protMask), .arrayData(arrayData),
    .statusFill(statusFill), .exceedFlag(exceedFlag),
    .rdValid(rdValid), .rdData(rdData)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int n6 = 0, n2 = 0, remain = 0;
  bit blk = 0;
  bit expValid = 0;
  logic [DATA_W-1:0] expData = '0;

  task automatic compare(input string tag);
    checks++;
    if (rdValid !== expValid || rdData !== expData) begin
      errors++;
      $display("FAIL %s: rdValid=%0b rdData=%h expected rdValid=%0b rdData=%h",
               tag, rdValid, rdData, expValid, expData);
    end
  endtask

  task automatic step(input string tag);
    bit sel, act, ectx, fb, show, f6, f2, live;
    fb   = remain > 0;
    sel  = eraseMask[rdSector];
    act  = (opMode == 3'd1) || (opMode == 3'd2) || (opMode == 3'd4);
    ectx = (opMode == 3'd2) || (opMode == 3'd3) || (opMode == 3'd4);
    expValid = rdStrobe;
    if (rdStrobe) begin
      f6   = fb || (!blk && act);
      f2   = !blk && ectx && sel;
      show = fb || (!blk && (act || (opMode == 3'd3 && sel)));
      if (f6) n6++;
      if (f2) n2++;
      if (show) begin
        expData    = statusFill;
        expData[6] = n6[0];
        expData[5] = exceedFlag;
        expData[2] = n2[0];
      end else begin
        expData = arrayData;
      end
    end
    if (cmdDone) begin
      n6 = 0;
      n2 = 0;
      if (opMode == 3'd1 || opMode == 3'd4) begin
        blk    = protMask[cmdSector];
        remain = blk ? SHORT_CYC : 0;
      end else if (opMode == 3'd2) begin
        live = 0;
        for (int i = 0; i < SECTORS; i++) if (eraseMask[i] && !protMask[i]) live = 1;
        blk    = !live;
        remain = blk ? LONG_CYC : 0;
      end else begin
        blk    = 0;
        remain = 0;
      end
    end else if (remain > 0) begin
      remain--;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rd(input int sec, input string tag);
    rdStrobe = 1'b1;
    rdSector = SEC_W'(sec);
    step(tag);
    rdStrobe = 1'b0;
  endtask

  task automatic cmd(input int m, input int sec, input string tag);
    opMode    = 3'(m);
    cmdSector = SEC_W'(sec);
    cmdDone   = 1'b1;
    step(tag);
    cmdDone   = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: run still active=1 expected finished=1");
    summary();
  end

  initial begin
    rstN = 1'b0; rdStrobe = 1'b0; rdSector = '0; opMode = 3'd0; cmdDone = 1'b0;
    cmdSector = '0; eraseMask = '0; protMask = '0; arrayData = 16'hA5C3;
    statusFill = 16'h1234; exceedFlag = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset");
    rstN = 1'b1;

    // R5: idle reads give array data
    rd(3, "R5"); rd(12, "R5");
    // R1: first busy read without any command gives bit6=1
    opMode = 3'd1;
    rd(0, "R1");

    // R2 / R6 / R9 / R10 / R11: normal program
    protMask = 16'h8000;
    cmd(1, 5, "R6");
    rd(0, "R2"); rd(7, "R11"); idle(2, "R9"); rd(9, "R2");
    exceedFlag = 1'b1; rd(1, "R10");
    statusFill = 16'hFFFF; rd(2, "R10");
    statusFill = 16'h0000; exceedFlag = 1'b0; rd(4, "R10");
    opMode = 3'd0; rd(4, "R5"); rd(6, "R5");

    // R3: active erase on sectors 2 and 3
    arrayData = 16'h5A0F;
    eraseMask = 16'h000C;
    cmd(2, 0, "R6");
    rd(2, "R3"); rd(3, "R3"); rd(5, "R3"); rd(2, "R3");

    // R4: erase suspended
    cmd(3, 0, "R4");
    rd(2, "R4"); rd(5, "R4"); rd(3, "R4"); rd(11, "R4");

    // R3: suspend-program, bit2 on selected sectors
    cmd(4, 8, "R3");
    rd(3, "R3"); rd(6, "R3"); rd(2, "R3");

    // R6: read in the same cycle as a new command
    rdStrobe = 1'b1; rdSector = 4'd2;
    cmd(4, 8, "R6 same-cycle");
    rdStrobe = 1'b0;
    rd(2, "R6"); rd(2, "R6");

    // R7: program to a protected sector, read every cycle past the window
    protMask = 16'h0100;
    cmd(1, 8, "R7");
    for (int i = 0; i < SHORT_CYC + 4; i++) rd(i % SECTORS, "R7");
    idle(3, "R7"); rd(0, "R7");

    // R6: unblocked command restores normal toggling
    cmd(1, 0, "R6"); rd(0, "R2"); rd(1, "R2");

    // R8: erase where every selected sector is protected
    eraseMask = 16'h0300; protMask = 16'h0300;
    cmd(2, 0, "R8");
    for (int i = 0; i < LONG_CYC + 4; i++) rd(8, "R8");
    rd(9, "R8");

    opMode = 3'd0; rd(1, "R5");
    idle(2, "R9");
    summary();
  end

endmodule